// File: doc/BRIEF.md
# Branch Resolution and Fetch Redirect Controller

This controller sits beside the decode stage of a five-stage in-order pipeline. It settles branch-if-equal instructions while they are still in decode and tells the fetch stage how to continue. A branch is taken when its two source registers are equal. The target is the incremented PC plus four times the sign-extended word offset.

The compare result and the operand-ready flag come from the register file and forwarding logic next to the block. The block returns three things: a next-PC select, a redirect address, and controls to hold fetch or to flush the IF/ID register. A counter of lost fetch cycles lets the cycle cost of each policy be measured.

A parameter picks one of three policies:
- Stall: every branch costs one bubble.
- Predict not-taken: only a taken branch costs a bubble.
- Delayed: the instruction after the branch always runs and there is no bubble.

The control state machine has three states:
- ST_FLOW: normal issue.
- ST_BUBBLE: decode holds a flushed slot.
- ST_SLOT: decode holds a delay-slot instruction.

Its transitions are:
- FLOW→FLOW when no branch is present, when a branch waits for operands, or when a predict-not-taken branch is not taken.
- FLOW→BUBBLE when a flush is issued.
- FLOW→SLOT when a delayed-policy branch resolves.
- BUBBLE→FLOW and SLOT→FLOW, unconditionally.

Top module: `brx_redirect_unit`

## Requirements
- R1: While npc_sel_o is 1 (redirect), redir_addr_o is id_npc_i + 4 × sext(id_offset_i) when id_regs_eq_i is 1, and id_npc_i otherwise.
- R2: A branch is treated as taken only when id_branch_i and id_regs_eq_i are both 1. Under the delayed and predict-not-taken policies, npc_sel_o is 1 only for a taken branch.
- R3: In ST_FLOW, a branch with id_ops_ready_i = 0 drives fetch_stall_o = 1 and npc_sel_o = 2 (hold), with no redirect and no flush. The state stays ST_FLOW.
- R4: Under the stall policy (POLICY = 0), every resolved branch asserts ifid_flush_o and npc_sel_o = 1 in the same cycle, whether or not it is taken.
- R5: Under predict not-taken (POLICY = 1), a taken branch asserts ifid_flush_o and npc_sel_o = 1 in the same cycle. A not-taken branch leaves npc_sel_o = 0 (sequential) and asserts no flush.
- R6: Under the delayed policy (POLICY = 2), ifid_flush_o is never asserted.
- R7: In the cycle after a flush, id_bubble_o is 1 and id_branch_i is ignored (npc_sel_o = 0, no flush, no stall).
- R8: Under the delayed policy, in the cycle after a resolved branch (the slot), id_branch_i is ignored and id_bubble_o is 0.
- R9: lost_cycles_o increases by exactly one after every cycle with ifid_flush_o or fetch_stall_o asserted, and holds otherwise.
- R10: After reset, npc_sel_o is 0, id_bubble_o is 0, and lost_cycles_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| id_branch_i | input | 1 | Decode stage holds a branch-if-equal |
| id_ops_ready_i | input | 1 | Both branch source operands are available |
| id_regs_eq_i | input | 1 | The two source registers compare equal |
| id_npc_i | input | XLEN | Incremented PC of the instruction in decode |
| id_offset_i | input | OFF_W | Signed word offset of the branch |
| npc_sel_o | output | 2 | Next-PC select: 0 sequential, 1 redirect, 2 hold |
| redir_addr_o | output | XLEN | Address fetched next when npc_sel_o is 1 |
| ifid_flush_o | output | 1 | Clear IF/ID to a bubble at the next edge |
| fetch_stall_o | output | 1 | Hold PC and IF/ID this cycle |
| id_bubble_o | output | 1 | Decode holds a flushed bubble; suppress its writes |
| lost_cycles_o | output | CNT_W | Running count of lost fetch cycles |

## Verification
Two events can fall in the same cycle: a branch arriving in decode, and the controller's own follow-up cycle, which is either the bubble after a flush or the delay slot. The bench provokes this by holding id_branch_i high, with equal operands, in the cycle right after each resolution.

All three policy instances see the same inputs. Only the predict-not-taken instance coming off a not-taken branch may act on that second flag. The stall and delayed instances, and the predict-not-taken instance after a taken branch, must keep npc_sel_o at 0 and leave the lost-cycle count unchanged.

The bench sweeps operand-wait lengths, the compare outcome and extreme offsets, and checks each cycle against an arithmetic model.

// File: rtl/brx_pkg.sv
package brx_pkg;

    typedef enum logic [1:0] {
        POL_STALL = 2'd0,
        POL_PNT   = 2'd1,
        POL_DELAY = 2'd2
    } brx_policy_e;

    typedef enum logic [1:0] {
        NPC_SEQ   = 2'd0,
        NPC_REDIR = 2'd1,
        NPC_HOLD  = 2'd2
    } brx_npc_e;

    typedef enum logic [1:0] {
        ST_FLOW   = 2'd0,
        ST_BUBBLE = 2'd1,
        ST_SLOT   = 2'd2
    } brx_state_e;

endpackage

// File: rtl/brx_target_calc.sv
module brx_target_calc #(
    parameter int XLEN  = 32,
    parameter int OFF_W = 16
) (
    input  logic [XLEN-1:0]  npc_i,
    input  logic [OFF_W-1:0] offset_i,
    input  logic             regs_eq_i,
    output logic             taken_o,
    output logic [XLEN-1:0]  redir_addr_o
);
    localparam int EXT_W = XLEN - OFF_W - 2;

    logic [XLEN-1:0] byte_off;
    logic [XLEN-1:0] target;

    assign byte_off     = {{EXT_W{offset_i[OFF_W-1]}}, offset_i, 2'b00};
    assign target       = npc_i + byte_off;
    assign taken_o      = regs_eq_i;
    assign redir_addr_o = taken_o ? target : npc_i;

endmodule

// File: rtl/brx_ctrl_fsm.sv
module brx_ctrl_fsm
    import brx_pkg::*;
#(
    parameter brx_policy_e POLICY = POL_PNT
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       branch_i,
    input  logic       ops_ready_i,
    input  logic       taken_i,
    output brx_npc_e   npc_sel_o,
    output logic       flush_o,
    output logic       fetch_stall_o,
    output logic       id_bubble_o
);
    brx_state_e st_q, st_d;
    logic       act_redir, act_flush;
    brx_state_e act_next;

    generate
        if (POLICY == POL_STALL) begin : g_stall
            assign act_redir = 1'b1;
            assign act_flush = 1'b1;
            assign act_next  = ST_BUBBLE;
        end else if (POLICY == POL_PNT) begin : g_pnt
            assign act_redir = taken_i;
            assign act_flush = taken_i;
            assign act_next  = taken_i ? ST_BUBBLE : ST_FLOW;
        end else begin : g_delay
            assign act_redir = taken_i;
            assign act_flush = 1'b0;
            assign act_next  = ST_SLOT;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_FLOW;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d          = st_q;
        npc_sel_o     = NPC_SEQ;
        flush_o       = 1'b0;
        fetch_stall_o = 1'b0;
        id_bubble_o   = 1'b0;
        unique case (st_q)
            ST_FLOW: begin
                if (branch_i && !ops_ready_i) begin
                    npc_sel_o     = NPC_HOLD;
                    fetch_stall_o = 1'b1;
                end else if (branch_i) begin
                    npc_sel_o = act_redir ? NPC_REDIR : NPC_SEQ;
                    flush_o   = act_flush;
                    st_d      = act_next;
                end
            end
            ST_BUBBLE: begin
                id_bubble_o = 1'b1;
                st_d        = ST_FLOW;
            end
            ST_SLOT: begin
                st_d = ST_FLOW;
            end
            default: st_d = ST_FLOW;
        endcase
    end

    p_flush_with_redirect_r4: assert property (@(posedge clk) disable iff (!rst_n)
        flush_o |-> (npc_sel_o == NPC_REDIR));

    p_wait_no_redirect_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_stall_o |-> (npc_sel_o == NPC_HOLD && !flush_o));

    p_wait_keeps_flow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_stall_o |=> (st_q == ST_FLOW));

    p_bubble_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
        flush_o |=> (id_bubble_o && npc_sel_o == NPC_SEQ));

    p_slot_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_SLOT) |-> (npc_sel_o == NPC_SEQ && !flush_o && !id_bubble_o));

endmodule

// File: rtl/brx_loss_cnt.sv
module brx_loss_cnt #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lose_i,
    output logic [CNT_W-1:0] count_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      count_o <= '0;
        else if (lose_i) count_o <= count_o + 1'b1;
    end

    p_step_one_r9: assert property (@(posedge clk) disable iff (!rst_n)
        lose_i |=> (count_o == CNT_W'($past(count_o) + 1'b1)));

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !lose_i |=> $stable(count_o));

endmodule

// File: rtl/brx_redirect_unit.sv
module brx_redirect_unit
    import brx_pkg::*;
#(
    parameter brx_policy_e POLICY = POL_PNT,
    parameter int          XLEN   = 32,
    parameter int          OFF_W  = 16,
    parameter int          CNT_W  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             id_branch_i,
    input  logic             id_ops_ready_i,
    input  logic             id_regs_eq_i,
    input  logic [XLEN-1:0]  id_npc_i,
    input  logic [OFF_W-1:0] id_offset_i,
    output logic [1:0]       npc_sel_o,
    output logic [XLEN-1:0]  redir_addr_o,
    output logic             ifid_flush_o,
    output logic             fetch_stall_o,
    output logic             id_bubble_o,
    output logic [CNT_W-1:0] lost_cycles_o
);
    logic     taken_w;
    brx_npc_e sel_w;

    brx_target_calc #(.XLEN(XLEN), .OFF_W(OFF_W)) u_calc (
        .npc_i        (id_npc_i),
        .offset_i     (id_offset_i),
        .regs_eq_i    (id_regs_eq_i),
        .taken_o      (taken_w),
        .redir_addr_o (redir_addr_o)
    );

    brx_ctrl_fsm #(.POLICY(POLICY)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .branch_i      (id_branch_i),
        .ops_ready_i   (id_ops_ready_i),
        .taken_i       (taken_w),
        .npc_sel_o     (sel_w),
        .flush_o       (ifid_flush_o),
        .fetch_stall_o (fetch_stall_o),
        .id_bubble_o   (id_bubble_o)
    );

    brx_loss_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .lose_i  (ifid_flush_o | fetch_stall_o),
        .count_o (lost_cycles_o)
    );

    assign npc_sel_o = sel_w;

    p_taken_needs_eq_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (npc_sel_o == 2'd1 && POLICY != POL_STALL) |-> (id_branch_i && id_regs_eq_i));

    p_redirect_needs_branch_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (npc_sel_o == 2'd1) |-> (id_branch_i && id_ops_ready_i));

endmodule

// File: tb/test_brx_redirect_unit.sv
`timescale 1ns/1ps
module test_brx_redirect_unit;
    import brx_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        br = 1'b0, rdy = 1'b0, eq = 1'b0;
    logic [31:0] npc = '0;
    logic [15:0] off = '0;

    logic [1:0]  sel   [3];
    logic [31:0] addr  [3];
    logic        fl    [3];
    logic        stl   [3];
    logic        bub   [3];
    logic [15:0] lost  [3];

    int nchk = 0;
    int nbad = 0;
    int ms   [3];
    int ecnt [3];

    always #2.5 clk = ~clk;

    brx_redirect_unit #(.POLICY(POL_STALL)) i_brx_redirect_unit (
        .clk(clk), .rst_n(rst_n), .id_branch_i(br), .id_ops_ready_i(rdy),
        .id_regs_eq_i(eq), .id_npc_i(npc), .id_offset_i(off),
        .npc_sel_o(sel[0]), .redir_addr_o(addr[0]), .ifid_flush_o(fl[0]),
        .fetch_stall_o(stl[0]), .id_bubble_o(bub[0]), .lost_cycles_o(lost[0]));

    brx_redirect_unit #(.POLICY(POL_PNT)) i_brx_redirect_unit_pnt (
        .clk(clk), .rst_n(rst_n), .id_branch_i(br), .id_ops_ready_i(rdy),
        .id_regs_eq_i(eq), .id_npc_i(npc), .id_offset_i(off),
        .npc_sel_o(sel[1]), .redir_addr_o(addr[1]), .ifid_flush_o(fl[1]),
        .fetch_stall_o(stl[1]), .id_bubble_o(bub[1]), .lost_cycles_o(lost[1]));

    brx_redirect_unit #(.POLICY(POL_DELAY)) i_brx_redirect_unit_dly (
        .clk(clk), .rst_n(rst_n), .id_branch_i(br), .id_ops_ready_i(rdy),
        .id_regs_eq_i(eq), .id_npc_i(npc), .id_offset_i(off),
        .npc_sel_o(sel[2]), .redir_addr_o(addr[2]), .ifid_flush_o(fl[2]),
        .fetch_stall_o(stl[2]), .id_bubble_o(bub[2]), .lost_cycles_o(lost[2]));

    task automatic chk(input string req, input string what, input int p,
                       input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s policy%0d %s: actual=%0h expected=%0h", req, p, what, act, exp);
        end
    endtask

    task automatic step(input logic b, input logic r, input logic e,
                        input logic [31:0] n, input logic [15:0] o);
        @(negedge clk);
        br = b; rdy = r; eq = e; npc = n; off = o;
        #1;
        for (int p = 0; p < 3; p++) begin
            logic act, wt, xf;
            logic [1:0]  xs;
            logic [31:0] xa;
            act = (ms[p] == 0) && b && r;
            wt  = (ms[p] == 0) && b && !r;
            xf  = act && (p == 0 || (p == 1 && e));
            xs  = wt ? 2'd2 : ((act && (p == 0 || e)) ? 2'd1 : 2'd0);
            xa  = e ? n + {{14{o[15]}}, o, 2'b00} : n;
            chk(wt ? "R3" : (ms[p] == 2 ? "R8" : (ms[p] == 1 ? "R7" :
                (p == 0 ? "R4" : (p == 1 ? "R5" : "R2")))), "npc_sel", p, 32'(sel[p]), 32'(xs));
            chk(p == 0 ? "R4" : (p == 1 ? "R5" : "R6"), "flush", p, 32'(fl[p]), 32'(xf));
            chk("R3", "fetch_stall", p, 32'(stl[p]), 32'(wt));
            chk(ms[p] == 2 ? "R8" : "R7", "bubble", p, 32'(bub[p]), 32'(ms[p] == 1));
            chk("R9", "lost_cycles", p, 32'(lost[p]), 32'(ecnt[p]));
            if (xs == 2'd1) chk("R1", "redir_addr", p, addr[p], xa);
            ecnt[p] = (ecnt[p] + ((wt || xf) ? 1 : 0)) & 16'hFFFF;
            ms[p]   = act ? (xf ? 1 : (p == 2 ? 2 : 0)) : 0;
        end
    endtask

    initial begin
        #(5.0 * 150000);
        nbad++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("  test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end

    initial begin
        for (int p = 0; p < 3; p++) begin ms[p] = 0; ecnt[p] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        for (int p = 0; p < 3; p++) begin
            chk("R10", "reset sel", p, 32'(sel[p]), 32'd0);
            chk("R10", "reset bubble", p, 32'(bub[p]), 32'd0);
            chk("R10", "reset lost", p, 32'(lost[p]), 32'd0);
        end
        rst_n = 1'b1;
        for (int e = 0; e < 2; e++) begin
            for (int w = 0; w < 3; w++) begin
                for (int k = 0; k < 4; k++) begin
                    logic [31:0] n;
                    logic [15:0] o;
                    n = 32'h0000_1000 + 32'(k * 256) + 32'(w * 16) + 32'(e * 4096);
                    case (k)
                        0:       o = 16'h0003;
                        1:       o = 16'hFFFE;
                        2:       o = 16'h8000;
                        default: o = 16'h7FFF;
                    endcase
                    for (int i = 0; i < w; i++) step(1'b1, 1'b0, e[0], n, o);
                    step(1'b1, 1'b1, e[0], n, o);
                    step(1'b1, 1'b1, 1'b1, n + 32'd4, o ^ 16'h0011);
                    step(1'b0, 1'b0, 1'b0, n + 32'd8, 16'h0000);
                    step(1'b0, 1'b0, 1'b0, n + 32'd12, 16'h0000);
                end
            end
        end
        step(1'b0, 1'b0, 1'b0, 32'h0, 16'h0);
        $display("  test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end

endmodule